// File: doc/BRIEF.md
# Qualified Event Performance Counter Bank

This block is a bank of four 48-bit event counters for a processor core. Every counter has its own configuration word. The word picks one event code from a per-cycle event input, in which each code reports from 0 to 3 occurrences in that cycle. The word also sets the qualifiers that decide whether an increment happens and how large it is:

- a threshold on the number of events in the cycle, which can be inverted;
- edge-only counting;
- filters by privilege level;
- a mask over cache-line states, used by the three cache refill and writeback events.

Software reaches the counters and their configuration words through a plain write port and a registered read port. When a counter wraps past all ones it sets a sticky overflow flag. If that counter has interrupts enabled, the flag drives a shared interrupt request until software rewrites the counter.

Edge-only counting uses a small state machine in each counter, with two states:
- **ARMED**: the qualified condition was false in the previous cycle. When the condition is true, the machine emits a one-cycle count pulse and moves to LATCHED (transition *fire*).
- **LATCHED**: the condition was already true. The machine stays in this state until the condition goes false, then returns to ARMED (transition *rearm*).

Top module: `qev_counter_bank`

## Requirements
- R1: After reset, every counter, every configuration word, every overflow flag, `rd_data_o` and `irq_o` are zero.
- R2: The configuration word is laid out as follows: `[7:0]` event select, `[11:8]` threshold, `[12]` invert, `[13]` edge, `[14]` kernel enable, `[15]` user enable, `[16]` interrupt enable, `[17]` counter enable, `[22:18]` state mask. With the threshold at zero, edge off and the privilege filters passing, an enabled counter adds the selected code's occurrence count every cycle. A disabled counter holds its value.
- R3: With a nonzero threshold T and invert clear, the counter adds exactly one in each cycle where the selected count is at least T, and nothing in other cycles.
- R4: With a nonzero threshold T and invert set, the counter adds one in each cycle where the selected count is below T.
- R5: With edge set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. Without a threshold, that condition is "count nonzero".
- R6: The privilege filters work on `cpl_i`:
  - the kernel enable passes only when `cpl_i` is 0;
  - the user enable passes when `cpl_i` is 1, 2 or 3;
  - when both enables are clear, every level passes.
- R7: Event codes 0x42, 0x43 and 0x44 take their count from `cache_cnt_i`. The contribution for event e (code minus 0x42) and state s sits at bits `[(e*5+s)*2 +: 2]`, with the states ordered Modified=0, Owner=1, Exclusive=2, Shared=3, Invalid=4. The count is the sum over the states whose mask bit is set, and a zero mask selects all states. Every other code k takes its count from `evt_cnt_i[k*2 +: 2]`.
- R8: An increment that carries a counter past 2^48-1 wraps the counter and sets that counter's sticky overflow flag. `irq_o` is high while any flagged counter has its interrupt enable set. A counter write clears that counter's flag.
- R9: A counter write (`wr_cfg_i`=0) loads `wr_data_i` and overrides any increment or wrap in the same cycle. A configuration write (`wr_cfg_i`=1) loads `wr_data_i[22:0]`. The increment in that same cycle still uses the old configuration.
- R10: `rd_data_o` shows, one clock after it is sampled, the value that the register chosen by `rd_idx_i`/`rd_cfg_i` held before that edge. A configuration word reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_i | input | 2 | Current privilege level |
| evt_cnt_i | input | 512 | Per-code occurrence counts, 2 bits per code |
| cache_cnt_i | input | 30 | Per-state counts for codes 0x42..0x44 |
| wr_en_i | input | 1 | Write strobe |
| wr_cfg_i | input | 1 | Write target: 1 configuration word, 0 counter |
| wr_idx_i | input | 2 | Counter index for the write |
| wr_data_i | input | 48 | Write data |
| rd_cfg_i | input | 1 | Read target: 1 configuration word, 0 counter |
| rd_idx_i | input | 2 | Counter index for the read |
| rd_data_o | output | 48 | Registered read data |
| ovf_o | output | 4 | Sticky overflow flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that meet in one cycle are a software counter write and a hardware increment on the same counter. The sharpest case is a write that lands in the very cycle an increment would wrap the counter past all ones.

The bench provokes both cases:
- It loads a counter near its limit, keeps its event busy, and issues a write exactly when the next increment would wrap.
- It writes a counter that is counting three events per cycle.

A behavioural model, updated every clock, judges the result. The counter must take the written value, gain no increment, and leave both the overflow flag and `irq_o` clear. The following cycle must resume counting from the written value.

// File: rtl/qev_pkg.sv
package qev_pkg;

    localparam int EVSEL_W = 8;
    localparam int THR_W   = 4;
    localparam int OCC_W   = 2;
    localparam int NSTATE  = 5;
    localparam int NMASKED = 3;
    localparam logic [EVSEL_W-1:0] MASKED_BASE = 8'h42;
    localparam int OCC_MAX = (1 << OCC_W) - 1;
    localparam int SUM_W   = $clog2(NSTATE * OCC_MAX + 1);
    localparam int CACHE_W = NMASKED * NSTATE * OCC_W;

    typedef struct packed {
        logic [NSTATE-1:0]  umask;
        logic               en;
        logic               ie;
        logic               usr;
        logic               os;
        logic               edge_m;
        logic               inv;
        logic [THR_W-1:0]   thr;
        logic [EVSEL_W-1:0] evsel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_LATCHED = 1'b1
    } edge_st_e;

endpackage

// File: rtl/qev_select.sv
module qev_select
    import qev_pkg::*;
#(
    parameter int NUM_CODES = 256
) (
    input  logic [EVSEL_W-1:0]          evsel_i,
    input  logic [NSTATE-1:0]           umask_i,
    input  logic [NUM_CODES*OCC_W-1:0]  evt_cnt_i,
    input  logic [CACHE_W-1:0]          cache_cnt_i,
    output logic [SUM_W-1:0]            occ_o
);

    localparam int PAD_W = SUM_W - OCC_W;

    logic masked_code;
    int   grp;

    assign masked_code = (evsel_i >= MASKED_BASE) &&
                         (evsel_i <  MASKED_BASE + EVSEL_W'(NMASKED));
    assign grp = int'(evsel_i - MASKED_BASE);

    always_comb begin
        occ_o = '0;
        if (masked_code) begin
            for (int s = 0; s < NSTATE; s++) begin
                if (umask_i == '0 || umask_i[s]) begin
                    occ_o = occ_o + {{PAD_W{1'b0}},
                            cache_cnt_i[(grp*NSTATE + s)*OCC_W +: OCC_W]};
                end
            end
        end else if (int'(evsel_i) < NUM_CODES) begin
            occ_o = {{PAD_W{1'b0}}, evt_cnt_i[int'(evsel_i)*OCC_W +: OCC_W]};
        end
    end

endmodule

// File: rtl/qev_qualify.sv
module qev_qualify
    import qev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg_i,
    input  logic [1:0]       cpl_i,
    input  logic [SUM_W-1:0] occ_i,
    output logic [SUM_W-1:0] inc_o
);

    edge_st_e   state_q, state_d;
    logic       priv_ok, cmp_ok, cond, pulse;
    logic [SUM_W-1:0] thr_ext;

    assign thr_ext = SUM_W'(cfg_i.thr);

    assign priv_ok = (!cfg_i.os && !cfg_i.usr) ||
                     (cfg_i.os  && cpl_i == 2'd0) ||
                     (cfg_i.usr && cpl_i != 2'd0);

    always_comb begin
        if (cfg_i.thr == '0)  cmp_ok = (occ_i != '0);
        else if (cfg_i.inv)   cmp_ok = (occ_i <  thr_ext);
        else                  cmp_ok = (occ_i >= thr_ext);
    end

    assign cond = cfg_i.en && priv_ok && cmp_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // next state: fire on a rising condition, rearm when it falls
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (cond)  state_d = ST_LATCHED;
            ST_LATCHED: if (!cond) state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        pulse = (state_q == ST_ARMED) && cond;
        if (cfg_i.edge_m)          inc_o = pulse ? SUM_W'(1) : '0;
        else if (cfg_i.thr != '0)  inc_o = cond  ? SUM_W'(1) : '0;
        else                       inc_o = cond  ? occ_i     : '0;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R5
    AST_THR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.thr != '0) |-> (inc_o <= SUM_W'(1))); // R3
    AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.os && !cfg_i.usr && cpl_i != 2'd0) |-> (inc_o == '0)); // R6

endmodule

// File: rtl/qev_slice.sv
module qev_slice
    import qev_pkg::*;
#(
    parameter int CNT_W     = 48,
    parameter int NUM_CODES = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_cfg_i,
    input  logic                        wr_cnt_i,
    input  logic [CNT_W-1:0]            wr_data_i,
    input  logic [1:0]                  cpl_i,
    input  logic [NUM_CODES*OCC_W-1:0]  evt_cnt_i,
    input  logic [CACHE_W-1:0]          cache_cnt_i,
    output cfg_t                        cfg_o,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        ovf_o
);

    cfg_t               cfg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_q;
    logic [SUM_W-1:0]   occ, inc;
    logic [CNT_W:0]     sum;

    qev_select #(.NUM_CODES(NUM_CODES)) sel_i (
        .evsel_i     (cfg_q.evsel),
        .umask_i     (cfg_q.umask),
        .evt_cnt_i   (evt_cnt_i),
        .cache_cnt_i (cache_cnt_i),
        .occ_o       (occ)
    );

    qev_qualify qual_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg_q),
        .cpl_i (cpl_i),
        .occ_i (occ),
        .inc_o (inc)
    );

    assign sum = {1'b0, cnt_q} + {{(CNT_W+1-SUM_W){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_cfg_i) cfg_q <= cfg_t'(wr_data_i[CFG_W-1:0]);
            if (wr_cnt_i) begin
                cnt_q <= wr_data_i;
                ovf_q <= 1'b0;
            end else begin
                cnt_q <= sum[CNT_W-1:0];
                if (sum[CNT_W]) ovf_q <= 1'b1;
            end
        end
    end

    assign cfg_o = cfg_q;
    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_q == $past(wr_data_i))); // R9
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !wr_cnt_i) |=> $stable(cnt_q)); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !wr_cnt_i) |=> ovf_q); // R8
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_i && cnt_q == '1 && inc != '0) |=> ovf_q); // R8

endmodule

// File: rtl/qev_counter_bank.sv
module qev_counter_bank
    import qev_pkg::*;
#(
    parameter int NUM_CTR   = 4,
    parameter int CNT_W     = 48,
    parameter int NUM_CODES = 256,
    localparam int IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cpl_i,
    input  logic [NUM_CODES*OCC_W-1:0]  evt_cnt_i,
    input  logic [CACHE_W-1:0]          cache_cnt_i,
    input  logic                        wr_en_i,
    input  logic                        wr_cfg_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [CNT_W-1:0]            wr_data_i,
    input  logic                        rd_cfg_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic [CNT_W-1:0]            rd_data_o,
    output logic [NUM_CTR-1:0]          ovf_o,
    output logic                        irq_o
);

    cfg_t             cfg_a [NUM_CTR];
    logic [CNT_W-1:0] cnt_a [NUM_CTR];
    logic [NUM_CTR-1:0] ie_v;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic hit;
        assign hit = wr_en_i && (int'(wr_idx_i) == g);

        qev_slice #(.CNT_W(CNT_W), .NUM_CODES(NUM_CODES)) slice_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_cfg_i    (hit && wr_cfg_i),
            .wr_cnt_i    (hit && !wr_cfg_i),
            .wr_data_i   (wr_data_i),
            .cpl_i       (cpl_i),
            .evt_cnt_i   (evt_cnt_i),
            .cache_cnt_i (cache_cnt_i),
            .cfg_o       (cfg_a[g]),
            .cnt_o       (cnt_a[g]),
            .ovf_o       (ovf_o[g])
        );

        assign ie_v[g] = cfg_a[g].ie;
    end

    assign irq_o = |(ovf_o & ie_v);

    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data_o <= '0;
        else if (rd_cfg_i) rd_data_o <= CNT_W'(cfg_a[rd_idx_i]);
        else               rd_data_o <= cnt_a[rd_idx_i];
    end

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_o != '0)); // R8

endmodule

// File: tb/qev_counter_bank_tb_top.sv
`timescale 1ns/1ps
module qev_counter_bank_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   cpl;
    logic [511:0] evt;
    logic [29:0]  cache;
    logic         wr_en, wr_cfg, rd_cfg;
    logic [1:0]   wr_idx, rd_idx;
    logic [47:0]  wr_data;
    logic [47:0]  rd_data;
    logic [3:0]   ovf;
    logic         irq;

    always #10 clk = ~clk;

    qev_counter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cpl_i(cpl), .evt_cnt_i(evt),
        .cache_cnt_i(cache), .wr_en_i(wr_en), .wr_cfg_i(wr_cfg),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_cfg_i(rd_cfg),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data), .ovf_o(ovf), .irq_o(irq)
    );

    // behavioural reference state
    logic [47:0] m_cnt  [4];
    logic [22:0] m_cfg  [4];
    logic        m_ovf  [4];
    logic        m_prev [4];
    logic [47:0] m_rd;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [47:0] mk(int code, int thr, bit inv, bit edg, bit os,
                                       bit us, bit ie, bit en, int mask);
        logic [47:0] w = '0;
        w[7:0] = code[7:0]; w[11:8] = thr[3:0]; w[12] = inv; w[13] = edg;
        w[14] = os; w[15] = us; w[16] = ie; w[17] = en; w[22:18] = mask[4:0];
        return w;
    endfunction

    function automatic int occ_of(logic [22:0] c);
        int code = int'(c[7:0]);
        int sum = 0;
        if (code >= 'h42 && code <= 'h44) begin
            for (int s = 0; s < 5; s++)
                if (c[22:18] == 5'd0 || c[18+s])
                    sum += int'(cache[((code-'h42)*5 + s)*2 +: 2]);
        end else begin
            sum = int'(evt[code*2 +: 2]);
        end
        return sum;
    endfunction

    task automatic step();
        logic [47:0] n_cnt [4];
        logic [22:0] n_cfg [4];
        logic        n_ovf [4];
        logic        n_prev [4];
        logic [47:0] n_rd;
        logic        exp_irq;
        for (int i = 0; i < 4; i++) begin
            logic [22:0] c = m_cfg[i];
            int  occ = occ_of(c);
            int  thr = int'(c[11:8]);
            bit  priv, cmp, cnd;
            int  inc;
            logic [48:0] sum;
            priv = (!c[14] && !c[15]) || (c[14] && cpl == 0) || (c[15] && cpl != 0);
            if (thr == 0)   cmp = (occ != 0);
            else if (c[12]) cmp = (occ < thr);
            else            cmp = (occ >= thr);
            cnd = c[17] && priv && cmp;
            if (c[13])         inc = (cnd && !m_prev[i]) ? 1 : 0;
            else if (thr != 0) inc = cnd ? 1 : 0;
            else               inc = cnd ? occ : 0;
            n_prev[i] = cnd;
            sum = {1'b0, m_cnt[i]} + 49'(inc);
            if (wr_en && !wr_cfg && wr_idx == i) begin
                n_cnt[i] = wr_data; n_ovf[i] = 1'b0;
            end else begin
                n_cnt[i] = sum[47:0]; n_ovf[i] = m_ovf[i] | sum[48];
            end
            n_cfg[i] = (wr_en && wr_cfg && wr_idx == i) ? wr_data[22:0] : m_cfg[i];
        end
        n_rd = rd_cfg ? {25'd0, m_cfg[rd_idx]} : m_cnt[rd_idx];
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = n_cnt[i]; m_cfg[i] = n_cfg[i];
            m_ovf[i] = n_ovf[i]; m_prev[i] = n_prev[i];
        end
        m_rd = n_rd;
        @(negedge clk);
        exp_irq = 1'b0;
        for (int i = 0; i < 4; i++) exp_irq |= m_ovf[i] & m_cfg[i][16];
        check(rd_data === m_rd, cur_req, rd_data, m_rd);
        check(irq === exp_irq, cur_req, 48'(irq), 48'(exp_irq));
        check(ovf === {m_ovf[3], m_ovf[2], m_ovf[1], m_ovf[0]}, cur_req, 48'(ovf),
              48'({m_ovf[3], m_ovf[2], m_ovf[1], m_ovf[0]}));
    endtask

    task automatic wr(input bit c, input int idx, input logic [47:0] d);
        wr_en = 1'b1; wr_cfg = c; wr_idx = idx[1:0]; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic setcnt(input int code, input int n);
        evt = '0;
        evt[code*2 +: 2] = n[1:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpl = '0; evt = '0; cache = '0;
        wr_en = 0; wr_cfg = 0; wr_idx = 0; wr_data = '0; rd_cfg = 0; rd_idx = 0;
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = '0; m_cfg[i] = '0; m_ovf[i] = 0; m_prev[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(rd_data === '0, "R1", rd_data, '0);
        check(irq === 1'b0, "R1", 48'(irq), '0);
        check(ovf === 4'd0, "R1", 48'(ovf), '0);
        rst_n = 1'b1;
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin
            rd_idx = i[1:0]; rd_cfg = 0; step();
            rd_cfg = 1; step();
        end

        // R10 configuration readback, R2 plain counting
        cur_req = "R10";
        wr(1, 0, mk('h40, 0, 0, 0, 0, 0, 0, 1, 0));
        rd_cfg = 1; rd_idx = 0; step(); step();
        rd_cfg = 0;
        cur_req = "R2";
        wr(1, 1, mk('h40, 0, 0, 0, 0, 0, 0, 0, 0));
        for (int k = 0; k < 12; k++) begin
            setcnt('h40, k % 4); rd_idx = k[0] ? 2'd1 : 2'd0; step();
        end

        // R3 threshold
        cur_req = "R3";
        wr(1, 1, mk('hC0, 2, 0, 0, 0, 0, 0, 1, 0));
        rd_idx = 1;
        for (int k = 0; k < 16; k++) begin setcnt('hC0, $urandom % 4); step(); end

        // R4 inverted threshold
        cur_req = "R4";
        wr(1, 2, mk('hC3, 2, 1, 0, 0, 0, 0, 1, 0));
        rd_idx = 2;
        for (int k = 0; k < 16; k++) begin setcnt('hC3, $urandom % 4); step(); end

        // R5 edge counting
        cur_req = "R5";
        wr(1, 3, mk('hC2, 0, 0, 1, 0, 0, 0, 1, 0));
        rd_idx = 3;
        for (int k = 0; k < 14; k++) begin
            setcnt('hC2, (k % 5 == 0) ? 0 : ((k % 3) + 1)); step();
        end
        wr(1, 3, mk('hC2, 2, 0, 1, 0, 0, 0, 1, 0));
        for (int k = 0; k < 12; k++) begin setcnt('hC2, $urandom % 4); step(); end

        // R6 privilege filters
        cur_req = "R6";
        wr(1, 0, mk('hCF, 0, 0, 0, 1, 0, 0, 1, 0));
        wr(1, 1, mk('hCF, 0, 0, 0, 0, 1, 0, 1, 0));
        wr(1, 2, mk('hCF, 0, 0, 0, 0, 0, 0, 1, 0));
        for (int k = 0; k < 12; k++) begin
            cpl = k[1:0]; setcnt('hCF, 1 + (k % 3)); rd_idx = 2'(k % 3); step();
        end
        cpl = 0;

        // R7 state mask on cache events
        cur_req = "R7";
        evt = '0;
        wr(1, 1, mk('h43, 0, 0, 0, 0, 0, 0, 1, 5'b01001));
        wr(1, 2, mk('h44, 0, 0, 0, 0, 0, 0, 1, 0));
        wr(1, 3, mk('h42, 3, 0, 0, 0, 0, 0, 1, 5'b10110));
        for (int k = 0; k < 18; k++) begin
            cache = 30'($urandom); rd_idx = 2'(1 + (k % 3)); step();
        end
        cache = '0;

        // R8 wrap, sticky flag, interrupt
        cur_req = "R8";
        wr(1, 2, mk('h40, 0, 0, 0, 0, 0, 1, 1, 0));
        wr(0, 2, 48'hFFFF_FFFF_FFFA);
        rd_idx = 2;
        for (int k = 0; k < 6; k++) begin setcnt('h40, 3); step(); end
        setcnt('h40, 0);
        step();
        wr(0, 2, 48'd5);
        step();

        // R9 write against increment, and against a wrap
        cur_req = "R9";
        wr(1, 0, mk('h40, 0, 0, 0, 0, 0, 1, 1, 0));
        setcnt('h40, 3); rd_idx = 0;
        step(); step();
        wr(0, 0, 48'd100);
        step(); step();
        wr(0, 0, 48'hFFFF_FFFF_FFFE);
        wr(0, 0, 48'd7);
        step(); step();
        wr(1, 3, mk('hC0, 0, 0, 0, 0, 0, 0, 1, 0));
        evt[('hC0)*2 +: 2] = 2'd2;
        wr(1, 3, mk('h40, 0, 0, 0, 0, 0, 0, 1, 0));
        rd_idx = 3; step(); step();

        // R10 read latency across rotating selections
        cur_req = "R10";
        for (int k = 0; k < 16; k++) begin
            rd_idx = 2'(k % 4); rd_cfg = k[2]; setcnt('h40, k % 4); step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule